// File: doc/BRIEF.md
# Subsystem Register Access Bridge

The bridge carries out the two instructions that move a word between the execution engine's register file and a register inside one of up to sixteen attached subsystems. It takes one 32-bit instruction word and decodes it. For a write it samples the engine register named in the word. It then raises a single request on the shared subsystem port. The request carries the subsystem id, the register index inside that subsystem, an 8-bit command that the bridge forwards without interpreting it, the direction and the write data.

The request stays up until the subsystem acknowledges it. Together with the acknowledge the subsystem returns read data and an error bit. A successful read writes the returned word into the engine register. A rejected access leaves the register file alone and pulses a privilege fault. Access policy belongs to each subsystem register and command, not to the opcode. A request that no subsystem answers within a fixed number of cycles is closed by the bridge itself as a privilege fault.

Top module: `ssb_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, `ssReq`, `busy`, `done`, `privFault` and `regWrEn` are all 0.
- R2: The instruction word is decoded LSB-first: opcode in bits [6:0], engine register in [11:7], subsystem id in [15:12], subsystem register in [23:16], command in [31:24]. Opcode 0x7D is a subsystem read and opcode 0x7E is a subsystem write. In the cycle after an accepted issue, `ssReq` is 1, `ssId`, `ssReg` and `ssCmd` equal those fields unchanged, and `ssWrite` is 1 for 0x7E and 0 for 0x7D.
- R3: An issue with any other opcode is ignored: no request, `busy` stays 0, and no `done` follows.
- R4: Once raised, `ssReq` and every request field stay constant until the cycle in which `ssAck` is sampled or the timeout expires.
- R5: `regRdIdx` always shows bits [11:7] of `instrWord`. For a write, `ssWrData` carries the `regRdData` value seen in the issue cycle.
- R6: A read acknowledged with `ssErr`=0 gives, in the cycle after the acknowledge, a one-cycle `regWrEn` with `regWrIdx` equal to the engine register field and `regWrData` equal to `ssRdData`, together with a one-cycle `done`.
- R7: A read acknowledged with `ssErr`=1 gives a one-cycle `done` and a one-cycle `privFault`, and `regWrEn` stays 0.
- R8: A write never asserts `regWrEn`. It completes with `done`, and `privFault` is 1 in that cycle exactly when `ssErr` was 1 with the acknowledge.
- R9: If no acknowledge is sampled during TIMEOUT_CYCLES request cycles, `ssReq` drops and `done` and `privFault` pulse together for one cycle, with no register write.
- R10: An acknowledge sampled in the last request cycle before the timeout takes priority. The result follows `ssAck` and `ssErr`, not the timeout.
- R11: An issue presented while `busy` is 1 is ignored. The request in flight keeps its fields, and no second request follows.
- R12: Every engine register index 0 to 31 is accepted in both directions, including index 31, which the engine uses as its program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction word presented this cycle |
| instrWord | input | 32 | Instruction to execute |
| busy | output | 1 | An access is in flight; issues are ignored |
| regRdIdx | output | 5 | Engine register read index (instruction bits [11:7]) |
| regRdData | input | 32 | Engine register value for `regRdIdx` |
| regWrEn | output | 1 | Engine register write strobe |
| regWrIdx | output | 5 | Engine register written |
| regWrData | output | 32 | Value written to the engine register |
| ssReq | output | 1 | Request to the subsystem port |
| ssId | output | 4 | Target subsystem |
| ssReg | output | 8 | Register inside the subsystem |
| ssCmd | output | 8 | Command forwarded unchanged |
| ssWrite | output | 1 | 1 = write, 0 = read |
| ssWrData | output | 32 | Write data |
| ssAck | input | 1 | Subsystem acknowledge |
| ssRdData | input | 32 | Read data, valid with `ssAck` |
| ssErr | input | 1 | Subsystem rejected the access, valid with `ssAck` |
| done | output | 1 | One-cycle completion pulse |
| privFault | output | 1 | One-cycle privilege fault pulse |

## Verification
Two of the bridge's functions can meet in one cycle. A subsystem may acknowledge in the same cycle that the timeout counter reaches its limit, and a new instruction may arrive while a request is still waiting. The bench provokes the first by holding the acknowledge back for exactly TIMEOUT_CYCLES-1 request cycles. It judges the result by the scoreboard: the read must write back with no fault. It provokes the second by presenting a different instruction one cycle into a pending access. It then checks that the request fields stay unchanged and that no second request follows the completion.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int OPC_W = 7;
  localparam logic [OPC_W-1:0] OP_SS_READ  = 7'h7D;
  localparam logic [OPC_W-1:0] OP_SS_WRITE = 7'h7E;

  typedef enum logic [0:0] {ST_IDLE, ST_WAIT} bridgeState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch instruction fields and write data
    logic complete;   // access finishes this cycle
    logic writeBack;  // load returned word into the engine register
    logic fault;      // report privilege fault
  } bridgeStrobes_t;
endpackage

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [OPC_W-1:0]     opcode,
  input  logic                 dirRead,
  input  logic                 ssAck,
  input  logic                 ssErr,
  output bridgeStrobes_t       strobes,
  output logic                 waiting
);
  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;

  bridgeState_t state;
  logic [CNT_W-1:0] waitCnt;
  logic isSsOp;
  logic timeUp;

  assign isSsOp  = (opcode == OP_SS_READ) || (opcode == OP_SS_WRITE);
  assign timeUp  = (waitCnt == CNT_W'(TIMEOUT_CYCLES - 1));
  assign waiting = (state == ST_WAIT);

  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE: strobes.capture = issueValid && isSsOp;
      ST_WAIT: begin
        if (ssAck) begin
          // acknowledge wins over an expiring timeout
          strobes.complete  = 1'b1;
          strobes.fault     = ssErr;
          strobes.writeBack = dirRead && !ssErr;
        end else if (timeUp) begin
          strobes.complete = 1'b1;
          strobes.fault    = 1'b1;
        end
      end
      default: strobes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      if (strobes.capture) begin
        state   <= ST_WAIT;
        waitCnt <= '0;
      end else if (strobes.complete) begin
        state   <= ST_IDLE;
      end else if (state == ST_WAIT) begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssb_datapath.sv
module ssb_datapath
  import ssb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int SS_ID_W   = 4,
  parameter int SS_REG_W  = 8,
  parameter int CMD_W     = 8,
  localparam int ENG_LSB  = OPC_W,
  localparam int ID_LSB   = ENG_LSB + REG_IDX_W,
  localparam int SREG_LSB = ID_LSB + SS_ID_W,
  localparam int CMD_LSB  = SREG_LSB + SS_REG_W,
  localparam int INSTR_W  = CMD_LSB + CMD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic [DATA_W-1:0]    regRdData,
  input  logic [DATA_W-1:0]    ssRdData,
  input  bridgeStrobes_t       strobes,
  output logic                 dirRead,
  output logic [REG_IDX_W-1:0] regRdIdx,
  output logic                 regWrEn,
  output logic [REG_IDX_W-1:0] regWrIdx,
  output logic [DATA_W-1:0]    regWrData,
  output logic [SS_ID_W-1:0]   ssId,
  output logic [SS_REG_W-1:0]  ssReg,
  output logic [CMD_W-1:0]     ssCmd,
  output logic                 ssWrite,
  output logic [DATA_W-1:0]    ssWrData,
  output logic                 done,
  output logic                 privFault
);
  assign regRdIdx = instrWord[ENG_LSB +: REG_IDX_W];
  assign dirRead  = !ssWrite;

  // request fields, frozen for the whole access
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrIdx <= '0;
      ssId     <= '0;
      ssReg    <= '0;
      ssCmd    <= '0;
      ssWrite  <= 1'b0;
      ssWrData <= '0;
    end else if (strobes.capture) begin
      regWrIdx <= instrWord[ENG_LSB +: REG_IDX_W];
      ssId     <= instrWord[ID_LSB +: SS_ID_W];
      ssReg    <= instrWord[SREG_LSB +: SS_REG_W];
      ssCmd    <= instrWord[CMD_LSB +: CMD_W];
      ssWrite  <= (instrWord[OPC_W-1:0] == OP_SS_WRITE);
      ssWrData <= regRdData;
    end
  end

  // completion results, single-cycle pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      privFault <= 1'b0;
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      done      <= strobes.complete;
      privFault <= strobes.complete && strobes.fault;
      regWrEn   <= strobes.complete && strobes.writeBack;
      if (strobes.writeBack) regWrData <= ssRdData;
    end
  end
endmodule

// File: rtl/ssb_bridge.sv
module ssb_bridge
  import ssb_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic [31:0] instrWord,
  output logic        busy,
  output logic [4:0]  regRdIdx,
  input  logic [31:0] regRdData,
  output logic        regWrEn,
  output logic [4:0]  regWrIdx,
  output logic [31:0] regWrData,
  output logic        ssReq,
  output logic [3:0]  ssId,
  output logic [7:0]  ssReg,
  output logic [7:0]  ssCmd,
  output logic        ssWrite,
  output logic [31:0] ssWrData,
  input  logic        ssAck,
  input  logic [31:0] ssRdData,
  input  logic        ssErr,
  output logic        done,
  output logic        privFault
);
  bridgeStrobes_t strobes;
  logic dirRead;
  logic waiting;

  ssb_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid),
    .opcode(instrWord[OPC_W-1:0]), .dirRead(dirRead),
    .ssAck(ssAck), .ssErr(ssErr), .strobes(strobes), .waiting(waiting)
  );

  ssb_datapath #(
    .DATA_W(32), .REG_IDX_W(5), .SS_ID_W(4), .SS_REG_W(8), .CMD_W(8)
  ) u_dp (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .regRdData(regRdData),
    .ssRdData(ssRdData), .strobes(strobes), .dirRead(dirRead),
    .regRdIdx(regRdIdx), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .ssId(ssId), .ssReg(ssReg), .ssCmd(ssCmd),
    .ssWrite(ssWrite), .ssWrData(ssWrData), .done(done), .privFault(privFault)
  );

  assign ssReq = waiting;
  assign busy  = waiting;
endmodule

// File: rtl/ssb_bridge_checker.sv
module ssb_bridge_checker #(
  parameter int TIMEOUT_CYCLES = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        issueValid,
  input logic        busy,
  input logic        regWrEn,
  input logic        ssReq,
  input logic [3:0]  ssId,
  input logic [7:0]  ssReg,
  input logic [7:0]  ssCmd,
  input logic        ssWrite,
  input logic [31:0] ssWrData,
  input logic        ssAck,
  input logic        ssErr,
  input logic        done,
  input logic        privFault
);
  int unsigned reqRun;

  always_ff @(posedge clk) begin
    if (!rstN) reqRun <= 0;
    else if (ssReq && !ssAck) reqRun <= reqRun + 1;
    else reqRun <= 0;
  end

  // R1: a request always shows as busy
  a_r1_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    ssReq |-> busy);

  // R2: completion only follows a live request
  a_r2_done_after_req: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(ssReq));

  // R3: a request only starts after an issue
  a_r3_req_from_issue: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssReq) |-> $past(issueValid));

  // R4: fields hold while the request waits
  a_r4_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ssReq && $past(ssReq)) |-> ($stable(ssId) && $stable(ssReg) &&
      $stable(ssCmd) && $stable(ssWrite) && $stable(ssWrData)));

  // R6: write-back only after a clean read acknowledge
  a_r6_wb_on_clean_read: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(ssReq && ssAck && !ssErr && !ssWrite));

  // R7: a fault never comes with a register write
  a_r7_fault_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    privFault |-> (done && !regWrEn));

  // R9: unanswered request never outlives the timeout
  a_r9_timeout_bound: assert property (@(posedge clk) disable iff (!rstN)
    reqRun <= TIMEOUT_CYCLES);

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind ssb_bridge ssb_bridge_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (.*);

// File: tb/ssb_bridge_bench.sv
module ssb_bridge_bench;
  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [31:0] instrWord;
  logic        busy;
  logic [4:0]  regRdIdx;
  logic [31:0] regRdData;
  logic        regWrEn;
  logic [4:0]  regWrIdx;
  logic [31:0] regWrData;
  logic        ssReq;
  logic [3:0]  ssId;
  logic [7:0]  ssReg;
  logic [7:0]  ssCmd;
  logic        ssWrite;
  logic [31:0] ssWrData;
  logic        ssAck;
  logic [31:0] ssRdData;
  logic        ssErr;
  logic        done;
  logic        privFault;

  always #10 clk = ~clk;  // 50 MHz

  ssb_bridge #(.TIMEOUT_CYCLES(TMO)) u_ssb_bridge (.*);

  typedef struct {
    logic        wb;
    logic [4:0]  idx;
    logic [31:0] data;
    logic        fault;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] op, input logic [4:0] eng,
      input logic [3:0] id, input logic [7:0] sreg, input logic [7:0] cmd);
    return {cmd, sreg, id, eng, op};
  endfunction

  // Monitor: pops expected results as completions appear
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (done) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2", "unexpected done", 32'd1, 32'd0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(privFault == e.fault, e.tag, "privFault", {31'd0, privFault}, {31'd0, e.fault});
          chk(regWrEn == e.wb, e.tag, "regWrEn", {31'd0, regWrEn}, {31'd0, e.wb});
          if (e.wb) begin
            chk(regWrIdx == e.idx, e.tag, "regWrIdx", {27'd0, regWrIdx}, {27'd0, e.idx});
            chk(regWrData == e.data, e.tag, "regWrData", regWrData, e.data);
          end
        end
      end else if (regWrEn || privFault) begin
        chk(1'b0, "R6", "strobe without done", {30'd0, regWrEn, privFault}, 32'd0);
      end
    end
  end

  // Driver: issue one access, play the subsystem, push the expected result
  task automatic access(input logic [6:0] op, input logic [4:0] eng,
      input logic [3:0] id, input logic [7:0] sreg, input logic [7:0] cmd,
      input logic [31:0] engVal, input int latency, input bit respond,
      input logic [31:0] rdVal, input bit err, input bit intrude, input string tag);
    expItem_t e;
    bit isRead;
    isRead = (op == 7'h7D);
    @(negedge clk);
    issueValid = 1'b1;
    instrWord  = mk(op, eng, id, sreg, cmd);
    regRdData  = engVal;
    #1;
    chk(regRdIdx == eng, "R5", "regRdIdx", {27'd0, regRdIdx}, {27'd0, eng});
    @(negedge clk);
    issueValid = 1'b0;
    regRdData  = 32'hDEAD_BEEF;
    chk(ssReq == 1'b1, tag, "ssReq raised (R2)", {31'd0, ssReq}, 32'd1);
    chk(ssId == id && ssReg == sreg && ssCmd == cmd, tag, "id/reg/cmd (R2)",
        {12'd0, ssId, ssReg, ssCmd}, {12'd0, id, sreg, cmd});
    chk(ssWrite == !isRead, tag, "ssWrite (R2)", {31'd0, ssWrite}, {31'd0, !isRead});
    if (!isRead) chk(ssWrData == engVal, "R5", "ssWrData", ssWrData, engVal);
    e.wb    = respond && isRead && !err;
    e.idx   = eng;
    e.data  = rdVal;
    e.fault = respond ? err : 1'b1;
    e.tag   = tag;
    expQ.push_back(e);
    if (respond) begin
      for (int i = 0; i < latency; i++) begin
        if (intrude && i == 0) begin
          issueValid = 1'b1;
          instrWord  = mk(7'h7E, 5'd2, ~id, ~sreg, ~cmd);
        end
        @(negedge clk);
        issueValid = 1'b0;
        chk(ssReq && ssId == id && ssReg == sreg && ssCmd == cmd && ssWrite == !isRead,
            intrude ? "R11" : "R4", "request held", {12'd0, ssId, ssReg, ssCmd},
            {12'd0, id, sreg, cmd});
      end
      ssAck    = 1'b1;
      ssRdData = rdVal;
      ssErr    = err;
      @(negedge clk);
      ssAck    = 1'b0;
      ssErr    = 1'b0;
      ssRdData = 32'h5555_AAAA;
      chk(ssReq == 1'b0, tag, "ssReq dropped", {31'd0, ssReq}, 32'd0);
    end else begin
      int n = 1;
      while (busy) begin
        @(negedge clk);
        if (busy) n++;
      end
      chk(n == TMO, "R9", "request cycles before timeout", n, TMO);
    end
    if (intrude) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(!ssReq && !busy, "R11", "no second request", {30'd0, ssReq, busy}, 32'd0);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; issueValid = 1'b0; instrWord = '0; regRdData = '0;
    ssAck = 1'b0; ssRdData = '0; ssErr = 1'b0;
    repeat (3) @(negedge clk);
    chk({ssReq, busy, done, privFault, regWrEn} == 5'b0, "R1", "outputs in reset",
        {27'd0, ssReq, busy, done, privFault, regWrEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk({ssReq, busy, done, privFault, regWrEn} == 5'b0, "R1", "outputs after reset",
        {27'd0, ssReq, busy, done, privFault, regWrEn}, 32'd0);

    // R2 R6: clean read with latency
    access(7'h7D, 5'd1, 4'd3, 8'h10, 8'h01, 32'h0, 2, 1, 32'hCAFE_F00D, 0, 0, "R6");
    // R8 R12: clean write from the program counter, immediate ack
    access(7'h7E, 5'd31, 4'd15, 8'h20, 8'h00, 32'h0000_1234, 0, 1, 32'h0, 0, 0, "R8");
    // R12: read into the program counter
    access(7'h7D, 5'd31, 4'd0, 8'hFF, 8'hA5, 32'h0, 1, 1, 32'h0010_0000, 0, 0, "R12");
    // R12: register 0 as target
    access(7'h7D, 5'd0, 4'd7, 8'h00, 8'h3C, 32'h0, 0, 1, 32'h8000_0001, 0, 0, "R12");
    // R7: rejected read
    access(7'h7D, 5'd4, 4'd2, 8'h40, 8'hFE, 32'h0, 1, 1, 32'hBAD0_BAD0, 1, 0, "R7");
    // R8: rejected write
    access(7'h7E, 5'd9, 4'd5, 8'h81, 8'h77, 32'h1357_9BDF, 3, 1, 32'h0, 1, 0, "R8");
    // R9: no subsystem answers, read then write
    access(7'h7D, 5'd6, 4'd12, 8'h02, 8'h10, 32'h0, 0, 0, 32'h0, 0, 0, "R9");
    access(7'h7E, 5'd7, 4'd13, 8'h03, 8'h11, 32'hFFFF_0000, 0, 0, 32'h0, 0, 0, "R9");
    // R10: acknowledge in the last request cycle
    access(7'h7D, 5'd11, 4'd1, 8'h55, 8'h02, 32'h0, TMO - 1, 1, 32'h0BAD_CAFE, 0, 0, "R10");
    // R11: issue while busy
    access(7'h7D, 5'd12, 4'd8, 8'h66, 8'h09, 32'h0, 2, 1, 32'h1111_2222, 0, 1, "R11");

    // R3: other opcodes ignored
    foreach (instrWord[i]) if (i < 2) begin end
    for (int k = 0; k < 3; k++) begin
      logic [6:0] op;
      op = (k == 0) ? 7'h00 : (k == 1) ? 7'h7F : 7'h7C;
      @(negedge clk);
      issueValid = 1'b1;
      instrWord  = mk(op, 5'd3, 4'd3, 8'h33, 8'h33);
      @(negedge clk);
      issueValid = 1'b0;
      for (int c = 0; c < 3; c++) begin
        chk(!ssReq && !busy && !done, "R3", "ignored opcode",
            {25'd0, op}, 32'd0);
        @(negedge clk);
      end
    end

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R2", "scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule